// File: doc/BRIEF.md
# Trace Buffer Write Pointer and Status Unit

This block advances the write pointer of a circular trace buffer held in memory and keeps a 64-bit status word that records buffer management events. Each cycle at most one trace byte is accepted. When the pointer sits on the last byte below the limit, it returns to the base and a sticky wrap bit is set. In fill mode that wrap also halts collection. A detected trigger is recorded in a sticky bit, and it halts collection when the trigger-stop input is high. A write fault, reported already encoded with its translation stage, a 6-bit fault code and an external-abort flag, halts collection and loads an abort class code together with the fault code.

Any halt sets the stopped bit and raises the maintenance interrupt. The interrupt stays high until software clears it. Software reads the status word directly from its output. Software writes take effect only while the buffer enable is low, so software can clear or replace the sticky state between collection runs. While the buffer is disabled, the pointer is preset from the base input, so each run starts at the base.

Top module: `tbuf_wptr_status`

## Requirements
- R1: Reset clears the write pointer and every bit of the status word, and drives the stopped and interrupt outputs low.
- R2: While the enable is low, the write pointer loads the base input on every cycle.
- R3: An accepted byte moves the pointer up by one. When the pointer equals limit minus one, the pointer reloads the base instead and status bit 20 (wrapped) becomes 1 and stays 1. In ring mode (fill select low), collection continues after the wrap.
- R4: In fill mode, a wrap halts collection. Status bit 17 (stopped) is set, bits 31:26 (class) become 0b000000, and bits 5:0 become 0b000001.
- R5: A trigger pulse during collection sets status bit 21 and the bit stays set. If the trigger-stop input is also high, collection halts, bit 17 is set and bits 5:0 become 0b000010.
- R6: A fault report halts collection. Bits 31:26 become 0b100100 for a stage 1 fault or 0b100101 for a stage 2 fault, and bits 5:0 take the reported fault code. If the external-abort flag is high, bit 18 is set as well.
- R7: When a fault and a fill-mode wrap occur in the same cycle, the class and code fields hold the fault syndrome.
- R8: Every halt sets status bit 22 and drives the interrupt output high. Both stay high until a software write clears bit 22.
- R9: Once stopped, the unit accepts no bytes, the pointer holds, and triggers and faults are not recorded, until software clears bit 17.
- R10: A software write while the enable is high leaves the status word unchanged.
- R11: A software write while the enable is low replaces the defined fields with the written data. Bits 63:32, 25:23, 19, 16 and 15:6 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_i | input | AW | Buffer base pointer |
| limit_i | input | AW | Buffer limit pointer (exclusive) |
| buf_en_i | input | 1 | Buffer enable |
| fill_mode_i | input | 1 | 1 = halt on wrap, 0 = keep wrapping |
| byte_acc_i | input | 1 | One trace byte offered this cycle |
| trig_i | input | 1 | Trigger detected pulse |
| trig_stop_i | input | 1 | Trigger halts collection |
| flt_valid_i | input | 1 | Write fault reported this cycle |
| flt_stage2_i | input | 1 | Fault is from stage 2 translation |
| flt_code_i | input | 6 | Encoded fault status code |
| flt_ext_i | input | 1 | Fault is an external abort |
| sw_wr_i | input | 1 | Software write strobe for the status word |
| sw_wdata_i | input | 64 | Software write data |
| wr_ptr_o | output | AW | Current write pointer |
| status_o | output | 64 | Status word (software read value) |
| stopped_o | output | 1 | Collection halted |
| irq_o | output | 1 | Maintenance interrupt |

## Verification
The pointer, every status field and both flag outputs come straight from registers. The effect of any input therefore appears on the outputs exactly one clock edge after the input is presented. The bench changes inputs on the falling edge and checks results on the next falling edge, after one rising edge has passed. It never looks earlier or later. Cases that expect nothing to change, such as bytes offered while stopped or a software write during enable, are checked at that same one-edge point, where a wrong update would already be visible.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;

  localparam int unsigned SR_W     = 64;
  localparam int unsigned CODE_W   = 6;
  localparam int unsigned BIT_IRQ  = 22;
  localparam int unsigned BIT_TRG  = 21;
  localparam int unsigned BIT_WRAP = 20;
  localparam int unsigned BIT_EA   = 18;
  localparam int unsigned BIT_STOP = 17;
  localparam int unsigned EC_LO    = 26;
  localparam int unsigned EC_HI    = 31;

  // defined (non-reserved) bits of the status word
  localparam logic [SR_W-1:0] USED_MASK = 64'h0000_0000_FC76_003F;

  localparam logic [CODE_W-1:0] CLS_OTHER = 6'b000000;
  localparam logic [CODE_W-1:0] CLS_ABT1  = 6'b100100;
  localparam logic [CODE_W-1:0] CLS_ABT2  = 6'b100101;
  localparam logic [CODE_W-1:0] ST_FILL   = 6'b000001;
  localparam logic [CODE_W-1:0] ST_TRIG   = 6'b000010;

  typedef struct packed {
    logic [CODE_W-1:0] cls;
    logic [CODE_W-1:0] code;
  } syn_t;

  // halt syndrome: a fault outranks a fill stop, which outranks a trigger stop
  function automatic syn_t halt_syndrome(input logic abort, input logic stage2,
                                         input logic [CODE_W-1:0] fcode,
                                         input logic fill_stop);
    syn_t s;
    if (abort) begin
      s.cls  = stage2 ? CLS_ABT2 : CLS_ABT1;
      s.code = fcode;
    end else if (fill_stop) begin
      s.cls  = CLS_OTHER;
      s.code = ST_FILL;
    end else begin
      s.cls  = CLS_OTHER;
      s.code = ST_TRIG;
    end
    return s;
  endfunction

endpackage

// File: rtl/tbuf_wptr.sv
module tbuf_wptr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  input  logic          en_i,
  input  logic          accept_i,
  output logic [AW-1:0] ptr_o,
  output logic          wrap_ev_o
);

  logic [AW-1:0] ptr_q;

  function automatic logic at_end(input logic [AW-1:0] p, input logic [AW-1:0] lim);
    return p == (lim - AW'(1));
  endfunction

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [AW-1:0] b,
                                         input logic [AW-1:0] lim);
    return at_end(p, lim) ? b : p + AW'(1);
  endfunction

  assign wrap_ev_o = accept_i && at_end(ptr_q, limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (!en_i)    ptr_q <= base_i;
    else if (accept_i) ptr_q <= step(ptr_q, base_i, limit_i);
  end

  assign ptr_o = ptr_q;

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && accept_i && !wrap_ev_o) |=> (ptr_q == $past(ptr_q) + AW'(1)));

  assert_wrap_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && wrap_ev_o) |=> (ptr_q == $past(base_i)));

  assert_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (ptr_q == $past(base_i)));

endmodule

// File: rtl/tbuf_syndrome.sv
module tbuf_syndrome
  import tbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_en_i,
  input  logic              sw_wr_i,
  input  logic [SR_W-1:0]   sw_wdata_i,
  input  logic              wrap_ev_i,
  input  logic              trig_ev_i,
  input  logic              abort_ev_i,
  input  logic              abort_s2_i,
  input  logic [CODE_W-1:0] abort_code_i,
  input  logic              abort_ext_i,
  input  logic              fill_stop_i,
  input  logic              trig_stop_i,
  output logic [SR_W-1:0]   sr_o
);

  logic [SR_W-1:0] sr_q, sr_d;
  logic            halt_ev;
  logic            sw_take;
  syn_t            syn;

  assign halt_ev = abort_ev_i || fill_stop_i || trig_stop_i;
  assign sw_take = sw_wr_i && !buf_en_i;
  assign syn     = halt_syndrome(abort_ev_i, abort_s2_i, abort_code_i, fill_stop_i);

  always_comb begin
    sr_d = sr_q;
    if (sw_take) begin
      sr_d = sw_wdata_i & USED_MASK;
    end else begin
      if (wrap_ev_i)                 sr_d[BIT_WRAP] = 1'b1;
      if (trig_ev_i)                 sr_d[BIT_TRG]  = 1'b1;
      if (abort_ev_i && abort_ext_i) sr_d[BIT_EA]   = 1'b1;
      if (halt_ev) begin
        sr_d[BIT_STOP]     = 1'b1;
        sr_d[BIT_IRQ]      = 1'b1;
        sr_d[EC_HI:EC_LO]  = syn.cls;
        sr_d[CODE_W-1:0]   = syn.code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sr_o = sr_q;

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_o & ~USED_MASK) == '0);

  assert_halt_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_ev && !sw_take) |=> (sr_o[BIT_STOP] && sr_o[BIT_IRQ]));

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_o[BIT_IRQ] && !sw_take) |=> sr_o[BIT_IRQ]);

  assert_abort_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev_i |=> (sr_o[EC_HI] && sr_o[EC_HI-3]));

  assert_wrap_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev_i |=> sr_o[BIT_WRAP]);

  assert_sw_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && buf_en_i && sr_o[BIT_STOP]) |=> $stable(sr_o));

endmodule

// File: rtl/tbuf_wptr_status.sv
module tbuf_wptr_status
  import tbuf_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     limit_i,
  input  logic              buf_en_i,
  input  logic              fill_mode_i,
  input  logic              byte_acc_i,
  input  logic              trig_i,
  input  logic              trig_stop_i,
  input  logic              flt_valid_i,
  input  logic              flt_stage2_i,
  input  logic [CODE_W-1:0] flt_code_i,
  input  logic              flt_ext_i,
  input  logic              sw_wr_i,
  input  logic [SR_W-1:0]   sw_wdata_i,
  output logic [AW-1:0]     wr_ptr_o,
  output logic [SR_W-1:0]   status_o,
  output logic              stopped_o,
  output logic              irq_o
);

  logic stopped;
  logic active;
  logic accept;
  logic wrap_ev;
  logic trig_ev;
  logic abort_ev;
  logic fill_stop;
  logic trig_stop;

  assign stopped   = status_o[BIT_STOP];
  assign active    = buf_en_i && !stopped;
  assign accept    = active && byte_acc_i;
  assign trig_ev   = active && trig_i;
  assign abort_ev  = active && flt_valid_i;
  assign fill_stop = wrap_ev && fill_mode_i;
  assign trig_stop = trig_ev && trig_stop_i;

  tbuf_wptr #(.AW(AW)) u_wptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_i    (base_i),
    .limit_i   (limit_i),
    .en_i      (buf_en_i),
    .accept_i  (accept),
    .ptr_o     (wr_ptr_o),
    .wrap_ev_o (wrap_ev)
  );

  tbuf_syndrome u_syn (
    .clk          (clk),
    .rst_n        (rst_n),
    .buf_en_i     (buf_en_i),
    .sw_wr_i      (sw_wr_i),
    .sw_wdata_i   (sw_wdata_i),
    .wrap_ev_i    (wrap_ev),
    .trig_ev_i    (trig_ev),
    .abort_ev_i   (abort_ev),
    .abort_s2_i   (flt_stage2_i),
    .abort_code_i (flt_code_i),
    .abort_ext_i  (flt_ext_i),
    .fill_stop_i  (fill_stop),
    .trig_stop_i  (trig_stop),
    .sr_o         (status_o)
  );

  assign stopped_o = stopped;
  assign irq_o     = status_o[BIT_IRQ];

  assert_hold_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_o && buf_en_i) |=> $stable(wr_ptr_o));

  assert_no_record_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_o && buf_en_i && !status_o[BIT_TRG]) |=> !status_o[BIT_TRG]);

endmodule

// File: tb/tbuf_wptr_status_tb.sv
module tbuf_wptr_status_tb_top;

  localparam int unsigned AW     = 16;
  localparam time         CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] base_i = '0, limit_i = '0;
  logic          buf_en_i = 0, fill_mode_i = 0, byte_acc_i = 0, trig_i = 0, trig_stop_i = 0;
  logic          flt_valid_i = 0, flt_stage2_i = 0, flt_ext_i = 0, sw_wr_i = 0;
  logic [5:0]    flt_code_i = '0;
  logic [63:0]   sw_wdata_i = '0;
  logic [AW-1:0] wr_ptr_o;
  logic [63:0]   status_o;
  logic          stopped_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  tbuf_wptr_status #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .base_i(base_i), .limit_i(limit_i),
    .buf_en_i(buf_en_i), .fill_mode_i(fill_mode_i), .byte_acc_i(byte_acc_i),
    .trig_i(trig_i), .trig_stop_i(trig_stop_i), .flt_valid_i(flt_valid_i),
    .flt_stage2_i(flt_stage2_i), .flt_code_i(flt_code_i), .flt_ext_i(flt_ext_i),
    .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i), .wr_ptr_o(wr_ptr_o),
    .status_o(status_o), .stopped_o(stopped_o), .irq_o(irq_o)
  );

  // expected status word built from field values
  function automatic logic [63:0] sw_word(input logic [5:0] cls, input bit irq, input bit trg,
                                          input bit wrap, input bit ea, input bit stp,
                                          input logic [5:0] code);
    logic [63:0] w = '0;
    w[31:26] = cls; w[22] = irq; w[21] = trg; w[20] = wrap;
    w[18] = ea; w[17] = stp; w[5:0] = code;
    return w;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // disable, clear the status word, preset pointer to base
  task automatic clear_all(input logic [AW-1:0] b, input logic [AW-1:0] l);
    buf_en_i = 0; base_i = b; limit_i = l;
    sw_wr_i = 1; sw_wdata_i = '0;
    cyc();
    sw_wr_i = 0;
  endtask

  task automatic t_reset();
    cyc(); cyc();
    chk("R1 ptr", 64'(wr_ptr_o), 64'h0);
    chk("R1 status", status_o, 64'h0);
    chk("R1 flags", {62'h0, stopped_o, irq_o}, 64'h0);
    rst_n = 1;
    cyc();
  endtask

  task automatic t_preset();
    base_i = 16'h0100; limit_i = 16'h0104; buf_en_i = 0;
    cyc();
    chk("R2 preset", 64'(wr_ptr_o), 64'h0100);
    base_i = 16'h0200;
    cyc();
    chk("R2 follow base", 64'(wr_ptr_o), 64'h0200);
  endtask

  task automatic t_ring();
    clear_all(16'h0100, 16'h0104);
    buf_en_i = 1; fill_mode_i = 0; byte_acc_i = 1;
    for (int i = 1; i <= 3; i++) begin
      cyc();
      chk("R3 step", 64'(wr_ptr_o), 64'(16'h0100 + i));
    end
    cyc();
    chk("R3 wrap ptr", 64'(wr_ptr_o), 64'h0100);
    chk("R3 wrap bit", status_o, sw_word(6'h0, 0, 0, 1, 0, 0, 6'h0));
    cyc();
    chk("R3 continues", 64'(wr_ptr_o), 64'h0101);
    byte_acc_i = 0;
  endtask

  task automatic t_fill();
    clear_all(16'h0100, 16'h0104);
    buf_en_i = 1; fill_mode_i = 1; byte_acc_i = 1;
    cyc(); cyc(); cyc(); cyc();
    chk("R4 ptr", 64'(wr_ptr_o), 64'h0100);
    chk("R4 status", status_o, sw_word(6'h0, 1, 0, 1, 0, 1, 6'h01));
    chk("R8 irq", {62'h0, stopped_o, irq_o}, 64'h3);
    cyc();
    chk("R9 ptr held", 64'(wr_ptr_o), 64'h0100);
    byte_acc_i = 0; trig_i = 1; flt_valid_i = 1; flt_code_i = 6'h05;
    cyc();
    trig_i = 0; flt_valid_i = 0;
    chk("R9 nothing recorded", status_o, sw_word(6'h0, 1, 0, 1, 0, 1, 6'h01));
    sw_wr_i = 1; sw_wdata_i = '0;
    cyc();
    sw_wr_i = 0;
    chk("R10 write ignored", status_o, sw_word(6'h0, 1, 0, 1, 0, 1, 6'h01));
    cyc();
    chk("R8 irq still held", {63'h0, irq_o}, 64'h1);
    buf_en_i = 0; sw_wr_i = 1;
    sw_wdata_i = 64'h8000_0001_0381_0040 | sw_word(6'h0, 0, 0, 1, 0, 0, 6'h00);
    cyc();
    sw_wr_i = 0;
    chk("R11 replace and reserved zero", status_o, sw_word(6'h0, 0, 0, 1, 0, 0, 6'h0));
    chk("R8 irq cleared", {62'h0, stopped_o, irq_o}, 64'h0);
    fill_mode_i = 0;
  endtask

  task automatic t_trigger();
    clear_all(16'h0300, 16'h0310);
    buf_en_i = 1; trig_i = 1; trig_stop_i = 0;
    cyc();
    trig_i = 0;
    chk("R5 trigger sticky", status_o, sw_word(6'h0, 0, 1, 0, 0, 0, 6'h0));
    cyc();
    chk("R5 stays set", status_o, sw_word(6'h0, 0, 1, 0, 0, 0, 6'h0));
    trig_i = 1; trig_stop_i = 1;
    cyc();
    trig_i = 0; trig_stop_i = 0;
    chk("R5 trigger stop", status_o, sw_word(6'h0, 1, 1, 0, 0, 1, 6'h02));
  endtask

  task automatic t_abort();
    clear_all(16'h0400, 16'h0410);
    buf_en_i = 1; flt_valid_i = 1; flt_stage2_i = 0; flt_code_i = 6'h07; flt_ext_i = 0;
    cyc();
    flt_valid_i = 0;
    chk("R6 stage 1", status_o, sw_word(6'b100100, 1, 0, 0, 0, 1, 6'h07));
    clear_all(16'h0400, 16'h0410);
    buf_en_i = 1; flt_valid_i = 1; flt_stage2_i = 1; flt_code_i = 6'h10; flt_ext_i = 1;
    cyc();
    flt_valid_i = 0; flt_stage2_i = 0; flt_ext_i = 0;
    chk("R6 stage 2 ext", status_o, sw_word(6'b100101, 1, 0, 0, 1, 1, 6'h10));
  endtask

  task automatic t_prio();
    clear_all(16'h0500, 16'h0504);
    buf_en_i = 1; fill_mode_i = 1; byte_acc_i = 1;
    cyc(); cyc(); cyc();
    flt_valid_i = 1; flt_code_i = 6'h0C;
    cyc();
    flt_valid_i = 0; byte_acc_i = 0;
    chk("R7 abort wins", status_o, sw_word(6'b100100, 1, 0, 1, 0, 1, 6'h0C));
    chk("R7 ptr wrapped", 64'(wr_ptr_o), 64'h0500);
    fill_mode_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_preset();
    t_ring();
    t_fill();
    t_trigger();
    t_abort();
    t_prio();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule